// File: doc/BRIEF.md
# Guarded Flash Erase Command Sequencer

This block sits between a small processor's byte-wide register write port and a flash array controller. Software starts an erase through a short guarded sequence. It first arms the operation by writing a setup register. It then writes a one-byte command code. A single-page erase needs a fresh page number. A whole-array erase needs a prior enable write, and the debug-enable input must also be high. A command byte that fails any of these checks is dropped, and nothing reaches the flash controller.

Once a command is accepted, the block raises a level request toward the flash controller. For a page erase, it also presents the page number it captured when the command was accepted. It keeps busy asserted until the controller returns a one-cycle done pulse. While busy, command writes are discarded. Setup writes still land in their registers. A status register reports busy and both arming flags, so software can poll progress and see why a command was refused.

Top module: `flash_erase_seq`

Register offsets on the 8-bit address bus: 0x10 page number, 0x11 full-erase enable, 0x12 command, 0x13 status. Status bits: bit 0 busy, bit 1 page armed, bit 2 full-erase armed, bits 7:3 zero.

## Requirements
- R1: After reset the page register reads 0x00, status reads 0x00, both requests and busy are low and erase_page is 0.
- R2: A write to offset 0x10 stores bits 6:0 and drops bit 7, so a readback of 0x10 never exceeds 127. The write sets the page-armed flag (status bit 1).
- R3: Writing 0x55 to offset 0x12 while idle and page-armed raises pg_erase_req and erase_busy on the next cycle. erase_page then holds the page number stored at that moment.
- R4: Writing 0x55 while not page-armed has no effect. An accepted page erase clears the page-armed flag, so a second 0x55 needs a new page write.
- R5: A write of any value to offset 0x11 sets the full-erase armed flag (status bit 2). Writing 0xAA to 0x12 while idle, armed and with dbg_en high raises mass_erase_req and erase_busy on the next cycle, and clears that flag.
- R6: Writing 0xAA with dbg_en low or without the full-erase arm starts nothing. Any command write accepted while idle that does not start a full erase clears the full-erase armed flag.
- R7: Any command byte other than 0x55 and 0xAA starts no erase and leaves the page-armed flag and the page register unchanged.
- R8: Busy and the active request stay high until a cycle with flash_done high, and fall on the following cycle. flash_done while idle has no effect.
- R9: While busy, command writes are ignored: no new request, and the arming flags do not change. Setup writes still update the page register and set the arming flags. erase_page stays constant for the whole operation.
- R10: A read of offset 0x12 always returns 0x00. A read of 0x11 returns 0x00, and a read of any unmapped offset returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register offset for read and write |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle while high |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| dbg_en | input | 1 | Debug-enable qualifier for full-array erase |
| flash_done | input | 1 | One-cycle completion pulse from the flash controller |
| pg_erase_req | output | 1 | Page erase request, held until done |
| mass_erase_req | output | 1 | Full-array erase request, held until done |
| erase_page | output | PAGE_W | Page number captured for the page erase |
| erase_busy | output | 1 | An erase is in progress |

## Verification
The bench targets single-use arming. A design that failed to clear the page arm would accept a second 0x55 with no new address, and one that forgot to clear the full-erase arm on a refused command would later accept a lone 0xAA. It drives 0xAA with dbg_en low, command bytes while busy, and done pulses while idle. A faulty design would start a full erase without debug, queue or start a command during an operation, or drop busy early. It also rewrites the page number during a page erase, where a design that shows the live register instead of the captured page would change erase_page in mid-operation.

// File: rtl/fes_pkg.sv
package fes_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_PAGE   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_MASSEN = 8'h11;
    localparam logic [ADDR_W-1:0] OFS_CMD    = 8'h12;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h13;

    localparam logic [DATA_W-1:0] CODE_PAGE = 8'h55;
    localparam logic [DATA_W-1:0] CODE_MASS = 8'hAA;

    typedef enum logic [1:0] {
        EK_IDLE = 2'd0,
        EK_PAGE = 2'd1,
        EK_MASS = 2'd2
    } erase_kind_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_wr_t;

    typedef struct packed {
        logic [4:0] zero;
        logic       mass_armed;
        logic       page_armed;
        logic       busy;
    } status_t;

    typedef struct packed {
        logic start_page;
        logic start_mass;
        logic cmd_taken;
    } cmd_verdict_t;

    function automatic logic hits(input bus_wr_t wr, input logic [ADDR_W-1:0] ofs);
        return wr.we && (wr.addr == ofs);
    endfunction

    function automatic status_t pack_status(input logic busy, input logic parm, input logic marm);
        status_t s;
        s.zero       = '0;
        s.mass_armed = marm;
        s.page_armed = parm;
        s.busy       = busy;
        return s;
    endfunction

endpackage

// File: rtl/fes_cmd_decode.sv
module fes_cmd_decode
    import fes_pkg::*;
(
    input  bus_wr_t      wr,
    input  logic         busy,
    input  logic         page_armed,
    input  logic         mass_armed,
    input  logic         dbg_en,
    output cmd_verdict_t verdict
);
    logic cmd_write;
    logic is_page_code;
    logic is_mass_code;

    always_comb begin
        cmd_write    = hits(wr, OFS_CMD) && !busy;
        is_page_code = (wr.data == CODE_PAGE);
        is_mass_code = (wr.data == CODE_MASS);

        verdict.cmd_taken  = cmd_write;
        verdict.start_page = cmd_write && is_page_code && page_armed;
        verdict.start_mass = cmd_write && is_mass_code && mass_armed && dbg_en;
    end
endmodule

// File: rtl/fes_regs.sv
module fes_regs
    import fes_pkg::*;
#(
    parameter int PAGE_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_wr_t           wr,
    input  cmd_verdict_t      verdict,
    output logic [PAGE_W-1:0] page_q,
    output logic              page_armed_q,
    output logic              mass_armed_q
);
    logic page_wr;
    logic massen_wr;

    always_comb begin
        page_wr   = hits(wr, OFS_PAGE);
        massen_wr = hits(wr, OFS_MASSEN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q       <= '0;
            page_armed_q <= 1'b0;
            mass_armed_q <= 1'b0;
        end else begin
            if (page_wr) begin
                page_q       <= wr.data[PAGE_W-1:0];
                page_armed_q <= 1'b1;
            end else if (verdict.start_page) begin
                page_armed_q <= 1'b0;
            end

            if (massen_wr) begin
                mass_armed_q <= 1'b1;
            end else if (verdict.cmd_taken) begin
                mass_armed_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/fes_ctrl.sv
module fes_ctrl
    import fes_pkg::*;
#(
    parameter int PAGE_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_verdict_t      verdict,
    input  logic [PAGE_W-1:0] page_q,
    input  logic              flash_done,
    output erase_kind_e       kind_q,
    output logic [PAGE_W-1:0] latched_page_q
);
    erase_kind_e kind_d;

    always_comb begin
        kind_d = kind_q;
        unique case (kind_q)
            EK_IDLE: begin
                if (verdict.start_page)      kind_d = EK_PAGE;
                else if (verdict.start_mass) kind_d = EK_MASS;
            end
            EK_PAGE, EK_MASS: begin
                if (flash_done) kind_d = EK_IDLE;
            end
            default: kind_d = EK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q         <= EK_IDLE;
            latched_page_q <= '0;
        end else begin
            kind_q <= kind_d;
            if (kind_q == EK_IDLE && verdict.start_page) begin
                latched_page_q <= page_q;
            end
        end
    end
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import fes_pkg::*;
#(
    parameter int PAGE_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_we,
    output logic [7:0]        bus_rdata,
    input  logic              dbg_en,
    input  logic              flash_done,
    output logic              pg_erase_req,
    output logic              mass_erase_req,
    output logic [PAGE_W-1:0] erase_page,
    output logic              erase_busy
);
    localparam int PAD_W = DATA_W - PAGE_W;

    bus_wr_t           wr;
    cmd_verdict_t      verdict;
    erase_kind_e       kind_q;
    logic [PAGE_W-1:0] page_q;
    logic [PAGE_W-1:0] latched_page_q;
    logic              page_armed_q;
    logic              mass_armed_q;
    logic              busy;
    status_t           status;

    always_comb begin
        wr.we   = bus_we;
        wr.addr = bus_addr;
        wr.data = bus_wdata;
    end

    assign busy = (kind_q != EK_IDLE);

    fes_cmd_decode u_decode (
        .wr         (wr),
        .busy       (busy),
        .page_armed (page_armed_q),
        .mass_armed (mass_armed_q),
        .dbg_en     (dbg_en),
        .verdict    (verdict)
    );

    fes_regs #(.PAGE_W(PAGE_W)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .wr           (wr),
        .verdict      (verdict),
        .page_q       (page_q),
        .page_armed_q (page_armed_q),
        .mass_armed_q (mass_armed_q)
    );

    fes_ctrl #(.PAGE_W(PAGE_W)) u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .verdict        (verdict),
        .page_q         (page_q),
        .flash_done     (flash_done),
        .kind_q         (kind_q),
        .latched_page_q (latched_page_q)
    );

    always_comb begin
        status = pack_status(busy, page_armed_q, mass_armed_q);
        unique case (bus_addr)
            OFS_PAGE:   bus_rdata = {{PAD_W{1'b0}}, page_q};
            OFS_STATUS: bus_rdata = status;
            default:    bus_rdata = '0;
        endcase
    end

    assign pg_erase_req   = (kind_q == EK_PAGE);
    assign mass_erase_req = (kind_q == EK_MASS);
    assign erase_busy     = busy;
    assign erase_page     = latched_page_q;
endmodule

// File: rtl/fes_checker.sv
module fes_checker
    import fes_pkg::*;
#(
    parameter int PAGE_W = 7
) (
    input logic              clk,
    input logic              rst,
    input logic [7:0]        bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_we,
    input logic              dbg_en,
    input logic              flash_done,
    input logic              pg_erase_req,
    input logic              mass_erase_req,
    input logic [PAGE_W-1:0] erase_page,
    input logic              erase_busy
);
    // R3 R5: at most one request at a time
    p_one_request_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pg_erase_req, mass_erase_req}));

    // R3: a page request starts only after a 0x55 command write
    p_page_start_cause_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(pg_erase_req) |-> $past(bus_we && bus_addr == OFS_CMD && bus_wdata == CODE_PAGE));

    // R6: a full erase never starts without debug enable
    p_mass_needs_debug_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(mass_erase_req) |-> $past(dbg_en && bus_we && bus_addr == OFS_CMD && bus_wdata == CODE_MASS));

    // R8: busy persists until done
    p_busy_holds_r8: assert property (@(posedge clk) disable iff (rst)
        erase_busy && !flash_done |=> erase_busy);

    // R8: done ends the operation
    p_done_ends_r8: assert property (@(posedge clk) disable iff (rst)
        erase_busy && flash_done |=> !erase_busy);

    // R9: page number steady during a page erase
    p_page_stable_r9: assert property (@(posedge clk) disable iff (rst)
        pg_erase_req && $past(pg_erase_req) |-> $stable(erase_page));

    // R9: no new request type while busy
    p_no_switch_r9: assert property (@(posedge clk) disable iff (rst)
        pg_erase_req && !flash_done |=> !mass_erase_req);
endmodule

bind flash_erase_seq fes_checker #(.PAGE_W(PAGE_W)) u_fes_checker (
    .clk            (clk),
    .rst            (rst),
    .bus_addr       (bus_addr),
    .bus_wdata      (bus_wdata),
    .bus_we         (bus_we),
    .dbg_en         (dbg_en),
    .flash_done     (flash_done),
    .pg_erase_req   (pg_erase_req),
    .mass_erase_req (mass_erase_req),
    .erase_page     (erase_page),
    .erase_busy     (erase_busy)
);

// File: tb/flash_erase_seq_test.sv
module flash_erase_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int PAGE_W     = 7;
    localparam int RESP_DELAY = 4;
    localparam int N_RANDOM   = 3000;

    localparam logic [7:0] A_PAGE = 8'h10;
    localparam logic [7:0] A_MEN  = 8'h11;
    localparam logic [7:0] A_CMD  = 8'h12;
    localparam logic [7:0] A_STAT = 8'h13;

    logic              clk = 1'b0;
    logic              rst;
    logic [7:0]        bus_addr;
    logic [7:0]        bus_wdata;
    logic              bus_we;
    logic [7:0]        bus_rdata;
    logic              dbg_en;
    logic              flash_done;
    logic              pg_erase_req;
    logic              mass_erase_req;
    logic [PAGE_W-1:0] erase_page;
    logic              erase_busy;

    int n_checks = 0;
    int n_fail   = 0;
    int resp_cnt = 0;
    bit auto_resp = 1'b1;

    // model state
    logic [6:0] m_page;
    logic       m_parm, m_marm, m_busy, m_is_mass;
    logic [6:0] m_epage;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_erase_seq #(.PAGE_W(PAGE_W)) uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .dbg_en(dbg_en),
        .flash_done(flash_done), .pg_erase_req(pg_erase_req),
        .mass_erase_req(mass_erase_req), .erase_page(erase_page),
        .erase_busy(erase_busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_status();
        return {5'b0, m_marm, m_parm, m_busy};
    endfunction

    task automatic model_reset();
        m_page = '0; m_parm = 0; m_marm = 0; m_busy = 0; m_is_mass = 0; m_epage = '0;
    endtask

    function automatic void model_step(input logic we, input logic [7:0] a,
                                       input logic [7:0] d, input logic dbg, input logic done);
        logic was_busy;
        was_busy = m_busy;
        if (was_busy && done) m_busy = 0;
        if (we && a == A_PAGE) begin
            m_page = d[6:0];
            m_parm = 1;
        end else if (we && a == A_MEN) begin
            m_marm = 1;
        end else if (we && a == A_CMD && !was_busy) begin
            if (d == 8'h55 && m_parm) begin
                m_busy = 1; m_is_mass = 0; m_epage = m_page; m_parm = 0;
            end else if (d == 8'hAA && m_marm && dbg) begin
                m_busy = 1; m_is_mass = 1;
            end
            m_marm = 0;
        end
    endfunction

    task automatic check_outputs(input string tag);
        chk({tag, " busy"}, erase_busy, m_busy);
        chk({tag, " page req"}, pg_erase_req, m_busy && !m_is_mass);
        chk({tag, " mass req"}, mass_erase_req, m_busy && m_is_mass);
        if (m_busy && !m_is_mass) chk({tag, " erase_page"}, erase_page, m_epage);
        bus_we = 0;
        bus_addr = A_STAT;
        #1 chk({tag, " status"}, bus_rdata, exp_status());
        bus_addr = A_PAGE;
        #1 chk("R2 page readback", bus_rdata, {1'b0, m_page});
        bus_addr = A_CMD;
        #1 chk("R10 cmd reads zero", bus_rdata, 8'h00);
    endtask

    // one bus cycle; done comes from the responder unless forced
    task automatic cycle(input logic we, input logic [7:0] a, input logic [7:0] d,
                         input logic dbg, input logic force_done, input string tag);
        logic done_v;
        @(negedge clk);
        if (erase_busy) resp_cnt++; else resp_cnt = 0;
        done_v = force_done || (auto_resp && erase_busy && resp_cnt >= RESP_DELAY);
        bus_we = we; bus_addr = a; bus_wdata = d; dbg_en = dbg; flash_done = done_v;
        model_step(we, a, d, dbg, done_v);
        @(posedge clk);
        #1;
        check_outputs(tag);
    endtask

    task automatic idle_until_free(input string tag);
        for (int i = 0; i < 20 && erase_busy; i++) cycle(0, 8'h00, 8'h00, 0, 0, tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] a, d;
        logic we, dbg;
        void'($urandom(32'h5EED_1234));
        rst = 1; bus_we = 0; bus_addr = 0; bus_wdata = 0; dbg_en = 0; flash_done = 0;
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        check_outputs("R1 reset");
        @(negedge clk); rst = 0;

        // R2: bit 7 dropped
        cycle(1, A_PAGE, 8'hFF, 0, 0, "R2 mask");
        // R3: page erase accepted
        cycle(1, A_CMD, 8'h55, 0, 0, "R3 page start");
        // R9: rewrite page during op, cmd ignored
        cycle(1, A_PAGE, 8'h05, 0, 0, "R9 page rewrite busy");
        cycle(1, A_CMD, 8'h55, 0, 0, "R9 cmd while busy");
        cycle(1, A_MEN, 8'h00, 1, 0, "R9 arm while busy");
        cycle(1, A_CMD, 8'hAA, 1, 0, "R9 mass cmd while busy");
        idle_until_free("R8 complete");
        // R4: page arm was set by the rewrite; consume and retry
        cycle(1, A_CMD, 8'h55, 0, 0, "R4 rearmed page start");
        idle_until_free("R8 complete");
        cycle(1, A_CMD, 8'h55, 0, 0, "R4 unarmed rejected");
        // R8: spurious done while idle
        auto_resp = 0;
        cycle(0, 8'h00, 8'h00, 0, 1, "R8 done idle ignored");
        auto_resp = 1;
        // R6: mass without debug, arm cleared
        cycle(1, A_MEN, 8'h01, 0, 0, "R5 arm mass");
        cycle(1, A_CMD, 8'hAA, 0, 0, "R6 no debug");
        cycle(1, A_CMD, 8'hAA, 1, 0, "R6 arm consumed");
        // R7: odd byte keeps page arm, clears mass arm
        cycle(1, A_PAGE, 8'h33, 1, 0, "R2 arm page");
        cycle(1, A_MEN, 8'h00, 1, 0, "R5 arm mass");
        cycle(1, A_CMD, 8'h5A, 1, 0, "R7 other byte");
        cycle(1, A_CMD, 8'hAA, 1, 0, "R6 cleared by other");
        // R5: full erase accepted
        cycle(1, A_MEN, 8'h00, 1, 0, "R5 arm mass");
        cycle(1, A_CMD, 8'hAA, 1, 0, "R5 mass start");
        // R8: hold done off to see busy held
        auto_resp = 0;
        repeat (6) cycle(0, 8'h00, 8'h00, 1, 0, "R8 held");
        cycle(0, 8'h00, 8'h00, 1, 1, "R8 done");
        auto_resp = 1;
        cycle(0, 8'h00, 8'h00, 1, 0, "R8 after done");
        cycle(1, A_CMD, 8'h55, 1, 0, "R3 page still armed start");
        idle_until_free("R8 complete");
        cycle(0, A_MEN, 8'h00, 0, 0, "R10 massen read");
        bus_addr = A_MEN; #1 chk("R10 massen reads zero", bus_rdata, 8'h00);
        bus_addr = 8'h7E; #1 chk("R10 unmapped reads zero", bus_rdata, 8'h00);

        for (int i = 0; i < N_RANDOM; i++) begin
            int r;
            r = $urandom_range(0, 9);
            we = ($urandom_range(0, 3) != 0);
            case (r)
                0, 1, 2: a = A_PAGE;
                3, 4:    a = A_MEN;
                5, 6, 7, 8: a = A_CMD;
                default: a = 8'($urandom);
            endcase
            case ($urandom_range(0, 4))
                0, 1: d = 8'h55;
                2:    d = 8'hAA;
                default: d = 8'($urandom);
            endcase
            dbg = ($urandom_range(0, 3) != 0);
            cycle(we, a, d, dbg, 0, "R3-7 random");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule